// File: doc/BRIEF.md
# Optical Black Level Averager

This block sits on the digitised output of a three-colour linear image sensor. Every pixel clock it receives one sample for each colour channel and the position of that sample within the line. The samples from a fixed window of light-shielded positions are summed per channel, and the sum is turned into a mean by multiplying it with a fixed-point reciprocal of the window length. That mean becomes the black reference for the channel.

The reference is latched before the first active pixel of the same line, so every active pixel of a line is corrected with the black level measured on that line. Each active sample has its channel's reference subtracted. Results below zero are clamped to zero. A valid flag marks the corrected active samples. The dummy positions at both ends of the line produce no output.

Top module: `obl_black_level`

## Requirements
- R1: Positions are counted from 0 at the first sample of a line. The black window covers positions OB_FIRST to OB_FIRST+OB_LEN-1 (default 17 to 66). The active span covers ACT_FIRST to ACT_FIRST+ACT_LEN-1 (default 69 to 5408). A line has LINE_LEN positions (default 5415).
- R2: `valid_o` is high exactly two clock cycles after a sample with an active position is presented, and low otherwise.
- R3: While `valid_o` is low, every bit of `pix_o` is zero. Samples at dummy positions never reach the output.
- R4: For each channel on its own, the black reference is floor(sum of the OB_LEN black-window samples / OB_LEN).
- R5: Samples outside the black window have no effect on the reference.
- R6: A high `line_start_i` clears all channel sums. The sample presented in the same cycle is the first one added, if its position lies in the black window.
- R7: The reference is updated by the last black-window position. It applies from the first active pixel of that same line.
- R8: A line in which the last black-window position never arrives keeps the reference of the earlier line. After reset the reference is 0.
- R9: A valid output equals the input sample minus its channel's reference. It is clamped to 0 when the sample is smaller than the reference.
- R10: Channel c occupies bits [c*DATA_W +: DATA_W] of `pix_i` and `pix_o`: channel 0 red, channel 1 green, channel 2 blue.
- R11: While `rst_ni` is low, `valid_o` and `pix_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | High with the first sample of a line |
| pix_idx_i | input | $clog2(LINE_LEN) | Position of the current sample within the line |
| pix_i | input | NUM_CH*DATA_W | Raw samples, one field per channel |
| pix_o | output | NUM_CH*DATA_W | Black-corrected samples, one field per channel |
| valid_o | output | 1 | Marks a corrected active sample on `pix_o` |

## Verification
The bench builds the block with 4-bit samples and a 20-position line. That line holds a 5-sample black window at positions 2 to 6 and 8 active pixels at positions 9 to 16. With these sizes, sweep lines drive every reference value 0 to 15 against every sample value 0 to 15 on all three channels, so every clamp boundary and every reciprocal rounding case is exercised. The bench also runs lines with random dummy values and random black levels, and it runs a short line that skips the black window to show that the earlier reference is held.

// File: rtl/obl_pkg.sv
package obl_pkg;
  // fractional bits for the reciprocal: the error stays below 1/ob_len for any full-window sum
  function automatic int unsigned mean_shift(int unsigned data_w, int unsigned ob_len);
    return data_w + 2 * $clog2(ob_len) + 1;
  endfunction
endpackage

// File: rtl/obl_window.sv
module obl_window #(
  parameter int IDX_W     = 13,
  parameter int OB_FIRST  = 17,
  parameter int OB_LEN    = 50,
  parameter int ACT_FIRST = 69,
  parameter int ACT_LEN   = 5340
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             ob_hit_o,
  output logic             ob_done_o,
  output logic             act_o
);
  localparam int OB_LAST  = OB_FIRST + OB_LEN - 1;
  localparam int ACT_LAST = ACT_FIRST + ACT_LEN - 1;

  int idx_int;
  logic ob_last, act_hit;

  assign idx_int  = int'(idx_i);
  assign ob_hit_o = (idx_int >= OB_FIRST) && (idx_int <= OB_LAST);
  assign ob_last  = (idx_int == OB_LAST);
  assign act_hit  = (idx_int >= ACT_FIRST) && (idx_int <= ACT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ob_done_o <= 1'b0;
      act_o     <= 1'b0;
    end else begin
      ob_done_o <= ob_last;
      act_o     <= act_hit;
    end
  end

  AST_DONE_NOT_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ob_done_o && act_o)); // R1
endmodule

// File: rtl/obl_accum.sv
module obl_accum #(
  parameter int DATA_W = 12,
  parameter int OB_LEN = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] ref_o
);
  localparam int SUM_W  = DATA_W + $clog2(OB_LEN + 1);
  localparam int SHIFT  = int'(obl_pkg::mean_shift(DATA_W, OB_LEN));
  localparam int PROD_W = SUM_W + SHIFT;
  localparam longint unsigned RECIP = ((64'd1 << SHIFT) + 64'(OB_LEN) - 64'd1) / 64'(OB_LEN);

  logic [SUM_W-1:0]  acc_q, acc_base, acc_d;
  logic [PROD_W-1:0] prod;

  assign acc_base = clear_i ? '0 : acc_q;
  assign acc_d    = acc_base + (hit_i ? SUM_W'(pix_i) : '0);
  assign prod     = PROD_W'(acc_q) * PROD_W'(RECIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ref_o <= '0;
    end else begin
      acc_q <= acc_d;
      if (done_i) ref_o <= prod[SHIFT +: DATA_W];
    end
  end

  AST_MEAN_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (prod[PROD_W-1:SHIFT+DATA_W] == '0)); // R4
  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(ref_o)); // R8
endmodule

// File: rtl/obl_sub.sv
module obl_sub #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [DATA_W-1:0] pix_i,
  input  logic [DATA_W-1:0] ref_i,
  output logic [DATA_W-1:0] pix_o
);
  logic [DATA_W:0] diff;

  assign diff = {1'b0, pix_i} - {1'b0, ref_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pix_o <= '0;
    else if (!act_i || diff[DATA_W]) pix_o <= '0;
    else                        pix_o <= diff[DATA_W-1:0];
  end

  AST_CLAMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && (ref_i > pix_i)) |=> (pix_o == '0)); // R9
  AST_NOT_ABOVE_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (pix_o <= $past(pix_i))); // R9
endmodule

// File: rtl/obl_black_level.sv
module obl_black_level #(
  parameter int NUM_CH    = 3,
  parameter int DATA_W    = 12,
  parameter int LINE_LEN  = 5415,
  parameter int OB_FIRST  = 17,
  parameter int OB_LEN    = 50,
  parameter int ACT_FIRST = 69,
  parameter int ACT_LEN   = 5340,
  localparam int IDX_W    = $clog2(LINE_LEN),
  localparam int BUS_W    = NUM_CH * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic [IDX_W-1:0] pix_idx_i,
  input  logic [BUS_W-1:0] pix_i,
  output logic [BUS_W-1:0] pix_o,
  output logic             valid_o
);
  logic ob_hit, ob_done, act_q;
  logic [BUS_W-1:0] s1_pix_q;

  obl_window #(
    .IDX_W(IDX_W), .OB_FIRST(OB_FIRST), .OB_LEN(OB_LEN),
    .ACT_FIRST(ACT_FIRST), .ACT_LEN(ACT_LEN)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(pix_idx_i),
    .ob_hit_o(ob_hit), .ob_done_o(ob_done), .act_o(act_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_pix_q <= '0;
      valid_o  <= 1'b0;
    end else begin
      s1_pix_q <= pix_i;
      valid_o  <= act_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] ref_c;

    obl_accum #(.DATA_W(DATA_W), .OB_LEN(OB_LEN)) u_accum (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(line_start_i), .hit_i(ob_hit),
      .pix_i(pix_i[c*DATA_W +: DATA_W]), .done_i(ob_done), .ref_o(ref_c)
    );

    obl_sub #(.DATA_W(DATA_W)) u_sub (
      .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_q),
      .pix_i(s1_pix_q[c*DATA_W +: DATA_W]), .ref_i(ref_c),
      .pix_o(pix_o[c*DATA_W +: DATA_W])
    );
  end

  AST_VALID_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((int'($past(pix_idx_i, 2)) >= ACT_FIRST) &&
                 (int'($past(pix_idx_i, 2)) < ACT_FIRST + ACT_LEN))); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (pix_o == '0)); // R3
endmodule

// File: tb/obl_black_level_bench.sv
module obl_black_level_bench;
  localparam int NC = 3, DW = 4, LL = 20, OBF = 2, OBL = 5, AF = 9, AL = 8;
  localparam int IW = $clog2(LL);
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ls;
  logic [IW-1:0] idx;
  logic [NC*DW-1:0] pin, pout;
  logic vout;

  obl_black_level #(
    .NUM_CH(NC), .DATA_W(DW), .LINE_LEN(LL), .OB_FIRST(OBF),
    .OB_LEN(OBL), .ACT_FIRST(AF), .ACT_LEN(AL)
  ) u_obl_black_level (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls), .pix_idx_i(idx),
    .pix_i(pin), .pix_o(pout), .valid_o(vout)
  );

  int checks = 0, errors = 0, filled = 0;
  bit done = 1'b0;
  int ref_m[NC];
  int sum_m[NC];
  logic e_v[2];
  logic [NC*DW-1:0] e_p[2];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one pixel clock: compare output of the sample driven two steps ago, then drive
  task automatic step(int i, bit l, logic [NC*DW-1:0] p);
    logic [NC*DW-1:0] ep;
    bit act;
    int v;
    @(negedge clk);
    if (filled >= 2) begin
      chk(vout == e_v[1], "R2 valid_o", int'(vout), int'(e_v[1]));
      for (int c = 0; c < NC; c++) begin
        if (e_v[1])
          chk(pout[c*DW +: DW] == e_p[1][c*DW +: DW], "R9 corrected sample (R4 R7 R10)",
              int'(pout[c*DW +: DW]), int'(e_p[1][c*DW +: DW]));
        else
          chk(pout[c*DW +: DW] == '0, "R3 idle output", int'(pout[c*DW +: DW]), 0);
      end
    end
    ep  = '0;
    act = (i >= AF) && (i < AF + AL);
    for (int c = 0; c < NC; c++) begin
      v = int'(p[c*DW +: DW]);
      if (l) sum_m[c] = 0;                                 // R6
      if (i >= OBF && i < OBF + OBL) sum_m[c] += v;        // R1 R5
      if (i == OBF + OBL - 1) ref_m[c] = sum_m[c] / OBL;   // R4 R7; else held (R8)
      if (act) ep[c*DW +: DW] = DW'((v > ref_m[c]) ? v - ref_m[c] : 0);
    end
    e_v[1] = e_v[0]; e_p[1] = e_p[0];
    e_v[0] = act;    e_p[0] = ep;
    filled++;
    idx = IW'(i); ls = l; pin = p;
  endtask

  function automatic logic [NC*DW-1:0] rnd_pix();
    logic [NC*DW-1:0] r;
    for (int c = 0; c < NC; c++) r[c*DW +: DW] = DW'($urandom_range(0, MAXV));
    return r;
  endfunction

  initial begin
    rst_n = 1'b0; ls = 1'b0; idx = IW'(LL - 1); pin = '0;
    for (int c = 0; c < NC; c++) begin ref_m[c] = 0; sum_m[c] = 0; end
    e_v[0] = 1'b0; e_v[1] = 1'b0; e_p[0] = '0; e_p[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(vout == 1'b0, "R11 valid_o in reset", int'(vout), 0);
    chk(pout == '0, "R11 pix_o in reset", int'(pout), 0);
    rst_n = 1'b1;

    // R8: active-only line right after reset, reference must be 0
    for (int i = AF; i < AF + AL; i++) step(i, i == AF, rnd_pix());

    // sweep: every reference against every sample value, per channel
    for (int r = 0; r <= MAXV; r++) begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < LL; i++) begin
          logic [NC*DW-1:0] p;
          if (i >= OBF && i < OBF + OBL) begin
            p[0*DW +: DW] = DW'(r);
            p[1*DW +: DW] = DW'(MAXV - r);
            p[2*DW +: DW] = DW'(r ^ 5);
          end else if (i >= AF && i < AF + AL) begin
            for (int c = 0; c < NC; c++) p[c*DW +: DW] = DW'((i - AF) + AL * h + c);
          end else begin
            p = rnd_pix(); // R5 dummy values must not matter
          end
          step(i, i == 0, p);
        end
      end
    end

    // random black levels with non-uniform windows (R4 rounding)
    for (int n = 0; n < 40; n++)
      for (int i = 0; i < LL; i++) step(i, i == 0, rnd_pix());

    // R8: line without black window keeps previous reference
    for (int i = AF; i < AF + AL; i++) step(i, i == AF, rnd_pix());
    for (int i = 0; i < LL; i++) step(i, i == 0, rnd_pix());

    step(LL - 1, 1'b0, rnd_pix());
    step(LL - 1, 1'b0, rnd_pix());
    step(LL - 1, 1'b0, '0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule